// File: doc/BRIEF.md
# Hamming ECC Checker and Corrector

This block judges one 512-byte data chunk by comparing two 3-byte Hamming codes. One code was read back from the spare area and the other was computed over the data as it was read. Each code is regrouped into two 12-bit parity halves, and the XOR of the two regrouped words forms the syndrome. The number of set syndrome bits decides the verdict.

A single flipped data bit sets exactly one bit in each parity pair, so it sets 12 syndrome bits. In that case the high half gives the byte offset and the bit to fix, and the block outputs the offset and a one-hot mask that the caller XORs into the buffered byte. A single set bit means the stored code itself is damaged. A chunk whose stored code is all ones and whose computed code is all zeros is a freshly erased page and is reported as good. Every other non-zero syndrome is reported as uncorrectable.

The block is a three-stage pipeline. It accepts a new pair of codes on every cycle that `start_i` is high and returns a verdict with a one-cycle `done_o` pulse. The outputs hold their last verdict until the next one arrives.

Top module: `ecc_hamming_fix`

## Requirements
- R1: Each code is taken as byte0 = bits 7:0, byte1 = bits 15:8 and byte2 = bits 23:16 of its input. It is regrouped into a low half {byte2[3:0], byte0} and a high half {byte2[7:4], byte1}. The syndrome is the XOR of the stored and computed halves.
- R2: A zero syndrome gives status 0 (clean).
- R3: A syndrome with exactly 12 bits set gives status 1 (corrected). The byte offset is high half bits 11:3, and the mask is a one-hot byte with bit (high half bits 2:0) set.
- R4: A syndrome with exactly 1 bit set gives status 2 (stored code corrupt).
- R5: A stored code of 0xFFFFFF together with a computed code of 0x000000 gives status 3 (erased, good).
- R6: Any other non-zero syndrome gives status 4 (uncorrectable).
- R7: `done_o` is high for exactly the cycle after the third rising edge, counting the edge that samples `start_i`. Starts on consecutive cycles give verdicts on consecutive cycles, in order.
- R8: For every status other than 1, the byte offset and the mask are zero.
- R9: While reset is asserted and after it is released, `done_o`, `status_o`, `byte_offs_o` and `bit_mask_o` are zero.
- R10: Without a start, the outputs keep the previous verdict even when the code inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Sample the two codes this cycle |
| stored_i | input | 24 | Code read from the spare area |
| calc_i | input | 24 | Code computed over the data |
| done_o | output | 1 | Verdict valid pulse |
| status_o | output | 3 | 0 clean, 1 corrected, 2 code corrupt, 3 erased, 4 uncorrectable |
| byte_offs_o | output | 9 | Byte to fix (0 to 511) |
| bit_mask_o | output | 8 | One-hot mask to XOR into that byte |

## Verification
A wrong bit count or a wrong half regrouping shows up on the next `done_o` pulse as a wrong status or as an offset and mask that point at the wrong bit. The sweep over every one of the 4096 correctable locations catches any swapped offset or mask bit within one verdict. A pipeline valid that drops, doubles or shifts shows up as a missing pulse, an extra pulse or a pulse one cycle early or late. Stale output registers show up as a non-zero mask alongside a non-corrected status.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  typedef enum logic [2:0] {
    ST_CLEAN    = 3'd0,
    ST_FIXED    = 3'd1,
    ST_CODE_BAD = 3'd2,
    ST_ERASED   = 3'd3,
    ST_UNCORR   = 3'd4
  } ecc_status_e;
endpackage

// File: rtl/ecc_code_unpack.sv
module ecc_code_unpack #(
  parameter int HALF_W = 12
) (
  input  logic [2*HALF_W-1:0] code_i,
  output logic [HALF_W-1:0]   lo_o,
  output logic [HALF_W-1:0]   hi_o
);
  localparam int NIB_W = HALF_W - 8;

  // byte2 nibbles extend the two 8-bit parity bytes to full halves
  assign lo_o = {code_i[16 +: NIB_W], code_i[7:0]};
  assign hi_o = {code_i[16+NIB_W +: NIB_W], code_i[15:8]};
endmodule

// File: rtl/ecc_popcount.sv
module ecc_popcount #(
  parameter int W     = 24,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CNT_W'(vec_i[i]);
  end
endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
  import ecc_fix_pkg::*;
#(
  parameter int HALF_W = 12,
  parameter int BIT_W  = 3,
  parameter int CNT_W  = 5
) (
  input  logic [HALF_W-1:0]       syn_hi_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic                    erased_i,
  output ecc_status_e             status_o,
  output logic [HALF_W-BIT_W-1:0] offs_o,
  output logic [(1<<BIT_W)-1:0]   mask_o
);
  localparam int MASK_W = 1 << BIT_W;

  logic [MASK_W-1:0] dec;
  logic              fix;

  for (genvar g = 0; g < MASK_W; g++) begin : g_dec
    assign dec[g] = (syn_hi_i[BIT_W-1:0] == BIT_W'(g));
  end

  always_comb begin
    fix = 1'b0;
    if (cnt_i == '0)                   status_o = ST_CLEAN;
    else if (cnt_i == CNT_W'(HALF_W)) begin
      status_o = ST_FIXED;
      fix      = 1'b1;
    end
    else if (cnt_i == CNT_W'(1))       status_o = ST_CODE_BAD;
    else if (erased_i)                 status_o = ST_ERASED;
    else                               status_o = ST_UNCORR;
  end

  assign offs_o = fix ? syn_hi_i[HALF_W-1:BIT_W] : '0;
  assign mask_o = fix ? dec : '0;
endmodule

// File: rtl/ecc_hamming_fix.sv
module ecc_hamming_fix
  import ecc_fix_pkg::*;
#(
  parameter int HALF_W = 12,
  parameter int BIT_W  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [2*HALF_W-1:0]     stored_i,
  input  logic [2*HALF_W-1:0]     calc_i,
  output logic                    done_o,
  output logic [2:0]              status_o,
  output logic [HALF_W-BIT_W-1:0] byte_offs_o,
  output logic [(1<<BIT_W)-1:0]   bit_mask_o
);
  localparam int CODE_W = 2 * HALF_W;
  localparam int OFFS_W = HALF_W - BIT_W;
  localparam int MASK_W = 1 << BIT_W;
  localparam int CNT_W  = $clog2(CODE_W + 1);

  logic [HALF_W-1:0] st_lo, st_hi, ca_lo, ca_hi;

  ecc_code_unpack #(.HALF_W(HALF_W)) u_unpack_st (
    .code_i(stored_i), .lo_o(st_lo), .hi_o(st_hi));
  ecc_code_unpack #(.HALF_W(HALF_W)) u_unpack_ca (
    .code_i(calc_i), .lo_o(ca_lo), .hi_o(ca_hi));

  // stage 1: syndrome and erased-page flag
  logic              v1_q, er1_q;
  logic [HALF_W-1:0] hi1_q, lo1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q  <= 1'b0;
      er1_q <= 1'b0;
      hi1_q <= '0;
      lo1_q <= '0;
    end else begin
      v1_q <= start_i;
      if (start_i) begin
        hi1_q <= st_hi ^ ca_hi;
        lo1_q <= st_lo ^ ca_lo;
        er1_q <= (&{st_hi, st_lo}) && ({ca_hi, ca_lo} == '0);
      end
    end
  end

  // stage 2: population count
  logic [CNT_W-1:0]  cnt_d, cnt2_q;
  logic              v2_q, er2_q;
  logic [HALF_W-1:0] hi2_q;

  ecc_popcount #(.W(CODE_W), .CNT_W(CNT_W)) u_pop (
    .vec_i({hi1_q, lo1_q}), .cnt_o(cnt_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v2_q   <= 1'b0;
      er2_q  <= 1'b0;
      hi2_q  <= '0;
      cnt2_q <= '0;
    end else begin
      v2_q <= v1_q;
      if (v1_q) begin
        er2_q  <= er1_q;
        hi2_q  <= hi1_q;
        cnt2_q <= cnt_d;
      end
    end
  end

  // stage 3: verdict
  ecc_status_e       st_d;
  logic [OFFS_W-1:0] offs_d;
  logic [MASK_W-1:0] mask_d;

  ecc_classify #(.HALF_W(HALF_W), .BIT_W(BIT_W), .CNT_W(CNT_W)) u_cls (
    .syn_hi_i(hi2_q), .cnt_i(cnt2_q), .erased_i(er2_q),
    .status_o(st_d), .offs_o(offs_d), .mask_o(mask_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      status_o    <= '0;
      byte_offs_o <= '0;
      bit_mask_o  <= '0;
    end else begin
      done_o <= v2_q;
      if (v2_q) begin
        status_o    <= st_d;
        byte_offs_o <= offs_d;
        bit_mask_o  <= mask_d;
      end
    end
  end
endmodule

// File: rtl/ecc_hamming_fix_chk.sv
module ecc_hamming_fix_chk #(
  parameter int HALF_W = 12,
  parameter int BIT_W  = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic                    done_o,
  input logic [2:0]              status_o,
  input logic [HALF_W-BIT_W-1:0] byte_offs_o,
  input logic [(1<<BIT_W)-1:0]   bit_mask_o
);
  // R7: verdict arrives three edges after the start is sampled
  a_r7_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == $past(start_i, 3));

  // R3: a corrected verdict carries exactly one mask bit
  a_r3_mask_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 3'd1) |-> $countones(bit_mask_o) == 1);

  // R8: no location is reported unless a fix is requested
  a_r8_no_loc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != 3'd1) |-> (bit_mask_o == '0 && byte_offs_o == '0));

  // R6: status stays inside the defined codes
  a_r6_legal_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o <= 3'd4);

  // R10: outputs only move when a verdict is delivered
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(status_o) && $stable(bit_mask_o) && $stable(byte_offs_o)));
endmodule

bind ecc_hamming_fix ecc_hamming_fix_chk #(.HALF_W(HALF_W), .BIT_W(BIT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .done_o(done_o),
  .status_o(status_o), .byte_offs_o(byte_offs_o), .bit_mask_o(bit_mask_o));

// File: tb/tb_ecc_hamming_fix.sv
`timescale 1ns/1ps
module tb_ecc_hamming_fix;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] stored_i = '0;
  logic [23:0] calc_i = '0;
  logic        done_o;
  logic [2:0]  status_o;
  logic [8:0]  byte_offs_o;
  logic [7:0]  bit_mask_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk_i = ~clk_i;

  ecc_hamming_fix dut (.*);

  function automatic logic [31:0] lcg(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  // codes from halves, per R1 byte placement
  function automatic logic [23:0] pack(input logic [11:0] hi, input logic [11:0] lo);
    return {hi[11:8], lo[11:8], hi[7:0], lo[7:0]};
  endfunction

  // {status, offset, mask} from R1..R6, R8
  function automatic logic [19:0] ref_fn(input logic [23:0] s, input logic [23:0] c);
    logic [23:0] x;
    logic [11:0] hi;
    int n;
    x  = s ^ c;
    hi = {x[23:20], x[15:8]};
    n  = 0;
    for (int i = 0; i < 24; i++) n += int'(x[i]);
    if (n == 0)  return {3'd0, 9'd0, 8'd0};
    if (n == 12) return {3'd1, hi[11:3], 8'(1 << hi[2:0])};
    if (n == 1)  return {3'd2, 9'd0, 8'd0};
    if (s == 24'hFFFFFF && c == 24'h0) return {3'd3, 9'd0, 8'd0};
    return {3'd4, 9'd0, 8'd0};
  endfunction

  task automatic check(input string tag, input logic [20:0] act, input logic [20:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act done/st/offs/mask=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] st);
    case (st)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      default: return "R6";
    endcase
  endfunction

  // one start, sample after the third edge (R7)
  task automatic run(input logic [23:0] s, input logic [23:0] c, input logic [19:0] exp, input string tag);
    @(negedge clk_i);
    stored_i = s; calc_i = c; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    @(negedge clk_i);
    check("R7 early", {20'd0, done_o}, 21'd0);
    @(negedge clk_i);
    check(tag, {done_o, status_o, byte_offs_o, bit_mask_o}, {1'b1, exp});
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [19:0] keep;
    // R9: reset state
    #35;
    check("R9 in reset", {done_o, status_o, byte_offs_o, bit_mask_o}, 21'd0);
    rst_ni = 1'b1;
    @(negedge clk_i); @(negedge clk_i);
    check("R9 after reset", {done_o, status_o, byte_offs_o, bit_mask_o}, 21'd0);

    // R3, R1: every correctable location
    for (int i = 0; i < 4096; i++) begin
      logic [11:0] loc;
      loc  = 12'(i);
      seed = lcg(seed);
      run(seed[23:0] ^ pack(loc, ~loc), seed[23:0],
          {3'd1, 9'(i >> 3), 8'(1 << (i & 7))}, "R3");
    end

    // R4: each single-bit syndrome
    for (int b = 0; b < 24; b++) begin
      seed = lcg(seed);
      run(seed[23:0] ^ (24'd1 << b), seed[23:0], {3'd2, 17'd0}, "R4");
    end

    // R2: equal codes
    for (int k = 0; k < 32; k++) begin
      seed = lcg(seed);
      run(seed[31:8], seed[31:8], 20'd0, "R2");
    end

    // R5: erased page; near-erased cases become R6
    run(24'hFFFFFF, 24'h000000, {3'd3, 17'd0}, "R5");
    run(24'hFFFFFF, 24'h000001, {3'd4, 17'd0}, "R6 near erased");
    run(24'hFFFFFE, 24'h000000, {3'd4, 17'd0}, "R6 near erased");
    run(24'h000000, 24'hFFFFFF, {3'd4, 17'd0}, "R6 swapped");

    // R6, R8: two-error syndromes and random pairs
    for (int k = 0; k < 1500; k++) begin
      logic [11:0] a, b;
      logic [23:0] s, c;
      seed = lcg(seed); a = seed[27:16];
      seed = lcg(seed); b = seed[27:16];
      seed = lcg(seed); c = seed[31:8];
      if (k[0]) s = c ^ pack(a, ~a) ^ pack(b, ~b);
      else begin seed = lcg(seed); s = seed[31:8]; end
      keep = ref_fn(s, c);
      run(s, c, keep, tag_of(keep[19:17]));
    end

    // R7: back-to-back starts give ordered consecutive verdicts
    begin
      logic [23:0] c0, c1, c2;
      c0 = 24'h3C5A69;
      c1 = c0 ^ pack(12'h5A5, ~12'h5A5);
      c2 = c0 ^ 24'h000800;
      @(negedge clk_i); stored_i = c0; calc_i = c0; start_i = 1'b1;
      @(negedge clk_i); stored_i = c1;
      @(negedge clk_i); stored_i = c2;
      @(negedge clk_i); start_i = 1'b0;
      check("R7 b2b 0", {done_o, status_o, byte_offs_o, bit_mask_o}, {1'b1, ref_fn(c0, c0)});
      @(negedge clk_i);
      check("R7 b2b 1", {done_o, status_o, byte_offs_o, bit_mask_o}, {1'b1, 3'd1, 9'h0B4, 8'h20});
      @(negedge clk_i);
      check("R7 b2b 2", {done_o, status_o, byte_offs_o, bit_mask_o}, {1'b1, 3'd2, 17'd0});
      @(negedge clk_i);
      check("R7 pulse ends", {20'd0, done_o}, 21'd0);
    end

    // R10: outputs hold while inputs move without start
    run(24'h111111 ^ pack(12'h00F, ~12'h00F), 24'h111111, {3'd1, 9'h001, 8'h80}, "R3");
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_i);
      stored_i = 24'hFFFFFF; calc_i = 24'(k);
    end
    check("R10 hold", {done_o, status_o, byte_offs_o, bit_mask_o}, {1'b0, 3'd1, 9'h001, 8'h80});

    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule